// File: doc/BRIEF.md
# Subrate HDLC Receive Channel

This block receives one channel of a time-division serial stream and recovers HDLC frames from it. The stream arrives one bit per clock while `ts_valid` is high. Every eight valid cycles form one timeslot, and the first valid cycle after reset is the first bit of a timeslot. A programmable slot mask chooses which bit positions of each timeslot belong to the channel. The chosen bits are compacted into a continuous bitstream, so a subrate channel can use only part of every timeslot. For example, mask `10111000` keeps four bits per slot, and two successive slots then supply one full octet.

The compacted bitstream goes to an HDLC deframer. The deframer hunts for flags, drops stuffed zeros, detects aborts and accumulates the 16-bit CCITT FCS. It delivers every received octet on a one-cycle `out_valid` strobe, with markers for frame start, frame end, abort and FCS/length error. The two FCS octets are delivered as the last two octets of each frame. After reset the channel is in HDLC mode and hunts for an opening flag.

Top module: `hdlc_subrate_rx`

## Requirements
- R1: After reset `out_valid` is 0. Bits received before the first flag (`01111110`) produce no output.
- R2: Only timeslot bits whose `slot_mask` bit is 1 reach the deframer. Mask bit 7 selects the first serial bit of a slot and bit 0 the last. Masked-out bits and cycles with `ts_valid` low have no effect.
- R3: Selected bits keep their arrival order. With mask `10111000`, slot n supplies four bits that come ahead of the four bits from slot n+1, and together they form one octet.
- R4: A flag opens a frame. The first octet delivered after it carries `out_sof`. HDLC bit order applies: the first deframed bit is `out_data[0]`.
- R5: A 0 that follows five consecutive 1s inside a frame is discarded and does not count toward an octet or the FCS.
- R6: A 0 followed by seven 1s aborts the frame. The last completed octet is delivered with `out_eof` and `out_abort` set, and the receiver returns to flag hunting.
- R7: At a closing flag the last octet carries `out_eof`. `out_fcs_err` is set unless the CRC (polynomial x^16+x^12+x^5+1, preset 0xFFFF, processed LSB first over all octets including the FCS) leaves the residue 0xF0B8.
- R8: A frame with fewer than three octets, or one whose closing flag does not fall on an octet boundary, is delivered with `out_fcs_err` set on its last octet.
- R9: Two frames that share a single flag, closing the first and opening the second, are both received correctly.
- R10: Each completed octet, including both FCS octets, is delivered exactly once, one cycle after the bit that completes the following octet or after the closing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_valid | input | 1 | Current bit belongs to this channel's timeslot |
| ts_bit | input | 1 | Serial data bit |
| slot_mask | input | SLOT_W | Bit positions of the slot that carry channel data |
| out_valid | output | 1 | Octet strobe, one cycle |
| out_data | output | 8 | Received octet |
| out_sof | output | 1 | First octet of a frame |
| out_eof | output | 1 | Last octet of a frame |
| out_abort | output | 1 | Frame ended by abort |
| out_fcs_err | output | 1 | Bad FCS, short frame or misaligned end |

## Verification
The assertions rely on `ts_valid` arriving in whole groups of eight that stay aligned to timeslots from reset onward. They also rely on `slot_mask` changing only between timeslots. The stimulus meets both conditions. Gaps with `ts_valid` low are inserted only between complete slots, with random data on the serial pin during the gaps. The mask is reloaded only at a slot start, after a closing flag and some idle ones. Every mask used has at least one bit set, so the compacted bitstream always advances.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int OCTET_W  = 8;
  localparam int FLAG_LEN = 8;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  typedef struct packed {
    logic                 sof;
    logic                 eof;
    logic                 abort;
    logic                 fcs_err;
    logic [OCTET_W-1:0]   data;
  } rx_octet_t;

  // one bit of the reflected CCITT CRC
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic [15:0] sh;
    sh = c >> 1;
    return (c[0] ^ b) ? (sh ^ CRC_POLY_R) : sh;
  endfunction
endpackage

// File: rtl/hdlc_mask_sel.sv
module hdlc_mask_sel #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_valid,
  input  logic              ts_bit,
  input  logic [SLOT_W-1:0] slot_mask,
  output logic              sel_en,
  output logic              sel_bit
);
  localparam int POS_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_W - 1);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (ts_valid) pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
  end

  // first serial bit of a slot is chosen by the top mask bit
  assign idx     = LAST_POS - pos;
  assign sel_en  = ts_valid & slot_mask[idx];
  assign sel_bit = ts_bit;

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && pos == LAST_POS) |=> (pos == '0)); // R3
  AST_GAP_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_valid |=> $stable(pos)); // R2
  AST_GAP_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_valid |-> !sel_en); // R2
endmodule

// File: rtl/hdlc_bit_sorter.sv
module hdlc_bit_sorter
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic flag_evt,
  output logic abort_evt,
  output logic stuff_evt,
  output logic data_en,
  output logic data_bit
);
  localparam int DLY = FLAG_LEN - 1;
  localparam int CW  = $clog2(FLAG_LEN);
  localparam logic [CW-1:0] FULL     = CW'(DLY);
  localparam logic [CW-1:0] RUN_FLAG = CW'(FLAG_LEN - 2);
  localparam logic [CW-1:0] RUN_STUF = CW'(FLAG_LEN - 3);
  localparam logic [CW-1:0] RUN_SAT  = '1;

  logic [CW-1:0]  ones;
  logic [CW-1:0]  pcnt;
  logic [DLY-1:0] pend;
  logic           zero_in, push;

  always_comb begin
    zero_in   = bit_en & ~bit_in;
    flag_evt  = zero_in & (ones == RUN_FLAG);
    stuff_evt = zero_in & (ones == RUN_STUF);
    abort_evt = bit_en & bit_in & (ones == RUN_FLAG);
    push      = bit_en & ~flag_evt & ~stuff_evt & ~abort_evt;
    data_en   = push & (pcnt == FULL);
    data_bit  = pend[DLY-1];
  end

  // run-length of ones on the line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ones <= '0;
    else if (bit_en) ones <= bit_in ? ((ones == RUN_SAT) ? ones : ones + 1'b1) : '0;
  end

  // bits wait here until they cannot be part of a flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      pcnt <= '0;
    end else if (flag_evt || abort_evt) begin
      pcnt <= '0;
    end else if (push) begin
      pend <= {pend[DLY-2:0], bit_in};
      if (pcnt != FULL) pcnt <= pcnt + 1'b1;
    end
  end

  AST_PEND_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_evt || abort_evt) |=> (pcnt == '0)); // R4
  AST_ZERO_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    zero_in |=> (ones == '0)); // R5
endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_OCTETS = 3,
  parameter int CNT_W      = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flag_evt,
  input  logic      abort_evt,
  input  logic      stuff_evt,
  input  logic      data_en,
  input  logic      data_bit,
  output logic      out_valid,
  output rx_octet_t out_rec
);
  localparam int BW = $clog2(OCTET_W);
  localparam logic [BW-1:0]    LAST_BIT = BW'(OCTET_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_OCTETS);

  logic                in_frame, hold_v, first_pend;
  logic [OCTET_W-1:0]  shreg, hold, next_oct;
  logic [BW-1:0]       bitcnt;
  logic [15:0]         crc;
  logic [CNT_W-1:0]    noct;
  logic                close_bad, take_bit;

  assign next_oct  = {data_bit, shreg[OCTET_W-1:1]};
  assign take_bit  = data_en & in_frame;
  assign close_bad = (noct < CNT_MIN) | (bitcnt != '0) | (crc != CRC_GOOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0; hold_v <= 1'b0; first_pend <= 1'b1;
      shreg <= '0; hold <= '0; bitcnt <= '0; crc <= CRC_PRESET; noct <= '0;
      out_valid <= 1'b0; out_rec <= '0;
    end else begin
      out_valid <= 1'b0;
      if (flag_evt) begin
        if (in_frame && hold_v) begin
          out_valid <= 1'b1;
          out_rec   <= '{sof: first_pend, eof: 1'b1, abort: 1'b0,
                         fcs_err: close_bad, data: hold};
        end
        in_frame <= 1'b1; hold_v <= 1'b0; first_pend <= 1'b1;
        bitcnt <= '0; crc <= CRC_PRESET; noct <= '0;
      end else if (abort_evt) begin
        if (in_frame && hold_v) begin
          out_valid <= 1'b1;
          out_rec   <= '{sof: first_pend, eof: 1'b1, abort: 1'b1,
                         fcs_err: 1'b0, data: hold};
        end
        in_frame <= 1'b0; hold_v <= 1'b0;
      end else if (take_bit) begin
        shreg  <= next_oct;
        bitcnt <= bitcnt + 1'b1;
        crc    <= crc16_step(crc, data_bit);
        if (bitcnt == LAST_BIT) begin
          if (hold_v) begin
            out_valid  <= 1'b1;
            out_rec    <= '{sof: first_pend, eof: 1'b0, abort: 1'b0,
                            fcs_err: 1'b0, data: hold};
            first_pend <= 1'b0;
          end
          hold   <= next_oct;
          hold_v <= 1'b1;
          if (noct != CNT_MAX) noct <= noct + 1'b1;
        end
      end
    end
  end

  AST_MARKS_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_rec.abort || out_rec.fcs_err)) |-> out_rec.eof); // R6
  AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !in_frame); // R6
  AST_FLAG_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt |=> (in_frame && bitcnt == '0 && crc == CRC_PRESET)); // R4
  AST_STUFF_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_evt |=> ($stable(bitcnt) && $stable(crc))); // R5
  AST_OCTET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && bitcnt == LAST_BIT && hold_v && !flag_evt && !abort_evt)
      |=> (out_valid && !out_rec.eof)); // R10
  AST_IDLE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !flag_evt) |=> !out_valid); // R1
endmodule

// File: rtl/hdlc_subrate_rx.sv
module hdlc_subrate_rx
  import hdlc_rx_pkg::*;
#(
  parameter int SLOT_W     = 8,
  parameter int MIN_OCTETS = 3,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_valid,
  input  logic              ts_bit,
  input  logic [SLOT_W-1:0] slot_mask,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_abort,
  output logic              out_fcs_err
);
  logic      sel_en, sel_bit;
  logic      flag_evt, abort_evt, stuff_evt, data_en, data_bit;
  rx_octet_t rec;

  hdlc_mask_sel #(.SLOT_W(SLOT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_bit(ts_bit),
    .slot_mask(slot_mask), .sel_en(sel_en), .sel_bit(sel_bit));

  hdlc_bit_sorter u_sort (
    .clk(clk), .rst_n(rst_n), .bit_en(sel_en), .bit_in(sel_bit),
    .flag_evt(flag_evt), .abort_evt(abort_evt), .stuff_evt(stuff_evt),
    .data_en(data_en), .data_bit(data_bit));

  hdlc_deframer #(.MIN_OCTETS(MIN_OCTETS), .CNT_W(CNT_W)) u_dfr (
    .clk(clk), .rst_n(rst_n), .flag_evt(flag_evt), .abort_evt(abort_evt),
    .stuff_evt(stuff_evt), .data_en(data_en), .data_bit(data_bit),
    .out_valid(out_valid), .out_rec(rec));

  assign out_data    = rec.data;
  assign out_sof     = rec.sof;
  assign out_eof     = rec.eof;
  assign out_abort   = rec.abort;
  assign out_fcs_err = rec.fcs_err;
endmodule

// File: tb/tb_hdlc_subrate_rx.sv
module tb_hdlc_subrate_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts_valid = 1'b0;
  logic ts_bit = 1'b0;
  logic [7:0] slot_mask = 8'hB8;
  logic out_valid, out_sof, out_eof, out_abort, out_fcs_err;
  logic [7:0] out_data;

  int nvec = 0;
  int nfail = 0;
  int run = 0;
  logic chan[$];
  logic [7:0] pay[$];
  logic [11:0] expq[$];
  string tagq[$];
  logic [11:0] got[$];

  always #5 clk = ~clk;

  hdlc_subrate_rx dut (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_bit(ts_bit),
    .slot_mask(slot_mask), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort),
    .out_fcs_err(out_fcs_err));

  always @(negedge clk)
    if (rst_n && out_valid) got.push_back({out_abort, out_fcs_err, out_eof, out_sof, out_data});

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  // bytewise reflected CRC, complemented for transmission
  function automatic logic [15:0] fcs_calc();
    logic [15:0] c = 16'hFFFF;
    foreach (pay[i]) begin
      c = c ^ {8'h00, pay[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push_bit(input logic b, input bit stuff);
    chan.push_back(b);
    if (stuff) begin
      if (b) begin
        run++;
        if (run == 5) begin chan.push_back(1'b0); run = 0; end
      end else run = 0;
    end
  endtask

  task automatic push_octet(input logic [7:0] b);
    for (int i = 0; i < 8; i++) push_bit(b[i], 1'b1);
  endtask

  task automatic push_flag();
    for (int i = 0; i < 8; i++) push_bit(8'h7E >> i, 1'b0);
    run = 0;
  endtask

  task automatic expect_rec(input logic [7:0] d, input logic sof, input logic eof,
                            input logic ab, input logic err, input string tag);
    expq.push_back({ab, err, eof, sof, d});
    tagq.push_back(tag);
  endtask

  task automatic rand_pay(input int n);
    pay.delete();
    for (int i = 0; i < n; i++) pay.push_back(8'($urandom));
  endtask

  // frame from pay[], then closing flag which also opens the next frame
  task automatic send_frame(input bit bad, input int extra, input string tag);
    logic [15:0] f;
    logic [7:0] all[$];
    int n;
    bit err;
    n = pay.size();
    f = fcs_calc() ^ (bad ? 16'h0001 : 16'h0000);
    all = pay;
    all.push_back(f[7:0]);
    all.push_back(f[15:8]);
    err = bad || (extra > 0) || (all.size() < 3);
    foreach (all[i]) begin
      bit last;
      string t;
      last = (i == all.size() - 1);
      push_octet(all[i]);
      if (last && err) t = (bad && extra == 0 && all.size() >= 3) ? "R7" : "R8";
      else if (last) t = "R7";
      else if (i >= n) t = "R10";
      else if (i == 0) t = (tag == "R3") ? "R3" : "R4";
      else t = tag;
      expect_rec(all[i], i == 0, last, 1'b0, last && err, t);
    end
    for (int i = 0; i < extra; i++) push_bit(1'($urandom), 1'b1);
    push_flag();
  endtask

  task automatic send_abort(input int k);
    rand_pay(k);
    foreach (pay[i]) begin
      push_octet(pay[i]);
      expect_rec(pay[i], i == 0, i == k - 1, i == k - 1, 1'b0, "R6");
    end
    push_bit(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) push_bit(1'b1, 1'b0);
    run = 0;
    push_flag();
  endtask

  task automatic play(input logic [7:0] m);
    slot_mask = m;
    while (chan.size() > 0) begin
      for (int p = 0; p < 8; p++) begin
        ts_valid = 1'b1;
        if (m[7-p]) ts_bit = (chan.size() > 0) ? chan.pop_front() : 1'b1;
        else        ts_bit = 1'($urandom);
        @(negedge clk);
      end
      ts_valid = 1'b0;
      repeat ($urandom_range(0, 2)) begin ts_bit = 1'($urandom); @(negedge clk); end
    end
    // idle ones, whole slots
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 8; p++) begin
        ts_valid = 1'b1;
        ts_bit = m[7-p] ? 1'b1 : 1'($urandom);
        @(negedge clk);
      end
    ts_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    nvec++;
    if (out_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R1 reset: out_valid actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: alternating data before any flag is ignored
    for (int i = 0; i < 32; i++) push_bit(i[0], 1'b0);
    play(8'hFF);
    nvec++;
    if (got.size() != 0) begin
      nfail++;
      $display("FAIL R1 pre-flag output: actual %0d octets expected 0", got.size());
    end
    got.delete();

    // 32 kb/s style subrate mask, directed corners
    push_flag();
    pay = '{8'hA5, 8'h3C, 8'h01};           send_frame(0, 0, "R3");
    pay = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8}; send_frame(0, 0, "R5");
    pay.delete();                           send_frame(0, 0, "R8");
    pay = '{8'h5A};                         send_frame(0, 0, "R3");
    rand_pay(4);                            send_frame(1, 0, "R7");
    rand_pay(4);                            send_frame(0, 3, "R8");
    send_abort(3);
    rand_pay(2);                            send_frame(0, 0, "R6");
    send_abort(1);
    play(8'hB8);

    // full-slot mask, back-to-back frames sharing flags
    push_flag();
    for (int f = 0; f < 8; f++) begin
      rand_pay($urandom_range(1, 12));
      send_frame(0, 0, "R9");
      if (f == 4) push_flag();
    end
    play(8'hFF);

    // sparse mask
    push_flag();
    for (int f = 0; f < 4; f++) begin
      rand_pay($urandom_range(1, 6));
      send_frame(f == 2, 0, "R2");
    end
    play(8'h81);

    // random masks
    for (int r = 0; r < 3; r++) begin
      logic [7:0] m;
      m = 8'($urandom);
      if (m == 8'h00) m = 8'h10;
      push_flag();
      for (int f = 0; f < 3; f++) begin
        rand_pay($urandom_range(1, 8));
        send_frame(0, 0, "R2");
      end
      play(m);
    end

    repeat (10) @(negedge clk);
    foreach (expq[i]) begin
      nvec++;
      if (i >= got.size()) begin
        nfail++;
        $display("FAIL %s octet %0d missing: actual none expected %h", tagq[i], i, expq[i]);
      end else if (got[i] !== expq[i]) begin
        nfail++;
        $display("FAIL %s octet %0d {abort,err,eof,sof,data}: actual %h expected %h",
                 tagq[i], i, got[i], expq[i]);
      end
    end
    nvec++;
    if (got.size() != expq.size()) begin
      nfail++;
      $display("FAIL R10 octet count: actual %0d expected %0d", got.size(), expq.size());
    end
    summary();
  end
endmodule